// File: doc/BRIEF.md
# ROM Patch Address-Match Unit

This unit sits in the instruction-fetch path between a CPU and its mask-programmed program ROM, so that faulty code in that ROM can be bypassed without changing the ROM itself. Software programs up to two correction addresses and turns on the channels it wants to use. From then on, every opcode fetch is compared with the armed addresses.

On a hit, the ROM byte is replaced by the first byte of a synthesized absolute jump. The following fetches receive the rest of that jump, so the CPU lands on a fixed patch entry vector (0xF7FD by default). A sticky per-channel flag records which channel fired, so the patch handler can dispatch to the right fix. The handler clears that flag by writing the control register.

Loading patch code into RAM, the RAM itself and the CPU core belong to other blocks. The unit only matches addresses, substitutes bytes and holds its small register set.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset, both correction addresses, all enable bits and all status bits read as 0, and `fetch_data` equals `rom_data`.
- R2: Register select 1 reads and writes the channel 0 correction address, and select 2 does the same for channel 1. Select 0 is the control register: bit 0 is channel 0 status, bit 1 channel 0 enable, bit 2 channel 1 status, bit 3 channel 1 enable. All other bits read 0. Select 3 reads 0.
- R3: A channel whose enable bit is 0 never triggers, whatever address it holds.
- R4: An opcode fetch (`fetch_valid` and `fetch_opcode` high) whose address equals an enabled channel's address, with no injection in progress, returns 0x9B in that same cycle instead of the ROM byte.
- R5: The next two cycles with `fetch_valid` high after such a hit return 0xFD and then 0xF7, the low and high bytes of the entry vector, whatever the fetch type or address.
- R6: A hit sets the status bit of every matching enabled channel from the next cycle on. The bit stays set until software writes the control register.
- R7: A control register write loads bits 3:0 from `reg_wdata`. Writing 0 disables both channels and clears both status bits. A hit in the same cycle as the write still sets its status bit.
- R8: Fetches with `fetch_opcode` low, while no injection is in progress, return `rom_data` unchanged even when the address matches.
- R9: When both channels are enabled and hold the same address, a hit injects one jump and sets both status bits.
- R10: While an injection is in progress, no new match is evaluated and no status bit is set.
- R11: Cycles with `fetch_valid` low do not advance the injection sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 channel 0 address, 2 channel 1 address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_opcode | input | 1 | The fetch is an opcode (first-byte) fetch |
| fetch_addr | input | 16 | Fetch address |
| rom_data | input | 8 | Byte read from ROM at `fetch_addr` |
| fetch_data | output | 8 | Byte returned to the CPU |

## Verification
The bench goes after a match presented while an injection is still running. A design that re-evaluates matches there would restart the jump or set the other channel's flag. It mixes idle cycles into the injection, because a sequencer that counts clocks rather than fetches would drop the 0xFD or 0xF7 byte. It also covers non-opcode reads of an armed address, where a sloppy comparator would corrupt operand data. It checks a control write that lands in the same cycle as a hit, where losing the hardware set would leave the handler unable to find its channel. Finally, it checks equal addresses on both channels, where a priority encoder applied to the flags would drop one of them.

// File: rtl/rom_patch_pkg.sv
package rom_patch_pkg;

   localparam int unsigned CH_COUNT = 2;
   localparam int unsigned SEL_W    = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADR0 = 2'd1,
      SEL_ADR1 = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // control layout: channel c status at bit 2c, enable at bit 2c+1
   function automatic int unsigned status_bit(input int unsigned ch);
      return 2 * ch;
   endfunction

   function automatic int unsigned enable_bit(input int unsigned ch);
      return 2 * ch + 1;
   endfunction

endpackage

// File: rtl/rom_patch_regs.sv
module rom_patch_regs
   import rom_patch_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned NCH    = CH_COUNT
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      sel,
   input  logic [ADDR_W-1:0]     wdata,
   input  logic [NCH-1:0]        set_req,
   output logic [ADDR_W-1:0]     rdata,
   output logic [NCH-1:0]        chan_en,
   output logic [NCH*ADDR_W-1:0] chan_addr
);

   localparam int unsigned CTRL_W = 2 * NCH;

   if (CTRL_W > ADDR_W) begin : g_ctrl_too_wide
      $error("control register does not fit the data width");
   end
   if (NCH + 1 > (1 << SEL_W)) begin : g_sel_too_narrow
      $error("register select cannot reach every channel");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic              ctrl_wr;

   assign ctrl_wr = wr_en && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q <= wdata[CTRL_W-1:0];
         end
         for (int c = 0; c < NCH; c++) begin
            if (set_req[c]) begin
               ctrl_q[status_bit(c)] <= 1'b1;
            end
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic [ADDR_W-1:0] addr_q;
      logic              sel_hit;

      assign sel_hit = wr_en && (int'(sel) == c + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
         end else if (sel_hit) begin
            addr_q <= wdata;
         end
      end

      assign chan_addr[c*ADDR_W +: ADDR_W] = addr_q;
      assign chan_en[c] = ctrl_q[enable_bit(c)];

      // R6
      status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_req[c] |=> ctrl_q[status_bit(c)]);
   end

   always_comb begin
      rdata = '0;
      if (sel == SEL_CTRL) begin
         rdata[CTRL_W-1:0] = ctrl_q;
      end
      for (int c = 0; c < NCH; c++) begin
         if (int'(sel) == c + 1) begin
            rdata = chan_addr[c*ADDR_W +: ADDR_W];
         end
      end
   end

   // R7
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata == '0 && set_req == '0) |=> (ctrl_q == '0));

endmodule

// File: rtl/rom_patch_cmp.sv
module rom_patch_cmp #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned NCH    = 2
) (
   input  logic [ADDR_W-1:0]     fetch_addr,
   input  logic [NCH-1:0]        chan_en,
   input  logic [NCH*ADDR_W-1:0] chan_addr,
   output logic [NCH-1:0]        match
);

   if (NCH < 1) begin : g_no_chan
      $error("at least one correction channel is required");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_cmp
      assign match[c] = chan_en[c] && (chan_addr[c*ADDR_W +: ADDR_W] == fetch_addr);
   end

endmodule

// File: rtl/rom_patch_inject.sv
module rom_patch_inject #(
   parameter int unsigned          ADDR_W    = 16,
   parameter int unsigned          DATA_W    = 8,
   parameter int unsigned          NCH       = 2,
   parameter logic [DATA_W-1:0]    BRANCH_OP = 8'h9B,
   parameter logic [ADDR_W-1:0]    VECTOR    = 16'hF7FD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic              fetch_opcode,
   input  logic [DATA_W-1:0] rom_data,
   input  logic [NCH-1:0]    match,
   output logic [DATA_W-1:0] fetch_data,
   output logic [NCH-1:0]    set_req
);

   localparam int unsigned VEC_BYTES = ADDR_W / DATA_W;
   localparam int unsigned INJ_LEN   = 1 + VEC_BYTES;
   localparam int unsigned CW        = $clog2(INJ_LEN);

   if (ADDR_W % DATA_W != 0) begin : g_bad_ratio
      $error("address width must be a whole number of data bytes");
   end

   logic [CW-1:0] seq_q;
   logic          busy;
   logic          start;

   assign busy  = (seq_q != '0);
   assign start = fetch_valid && fetch_opcode && !busy && (|match);

   function automatic logic [DATA_W-1:0] inj_byte(input logic [CW-1:0] idx);
      logic [ADDR_W-1:0] shifted;
      shifted = VECTOR >> ((int'(idx) - 1) * DATA_W);
      return shifted[DATA_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
      end else if (start) begin
         seq_q <= CW'(1);
      end else if (busy && fetch_valid) begin
         seq_q <= (seq_q == CW'(INJ_LEN - 1)) ? '0 : seq_q + CW'(1);
      end
   end

   always_comb begin
      if (fetch_valid && busy) begin
         fetch_data = inj_byte(seq_q);
      end else if (start) begin
         fetch_data = BRANCH_OP;
      end else begin
         fetch_data = rom_data;
      end
   end

   assign set_req = start ? match : '0;

   // R4
   branch_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_opcode && !busy && (|match)) |-> (fetch_data == BRANCH_OP));

   // R8
   operand_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_opcode && !busy) |-> (fetch_data == rom_data));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> $stable(seq_q));

   // R10
   busy_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (set_req == '0));

endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
   import rom_patch_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [7:0]        BRANCH_OP = 8'h9B,
   parameter logic [15:0]       VECTOR    = 16'hF7FD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              fetch_valid,
   input  logic              fetch_opcode,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0] rom_data,
   output logic [DATA_W-1:0] fetch_data
);

   localparam int unsigned NCH = CH_COUNT;

   logic [NCH-1:0]        chan_en;
   logic [NCH*ADDR_W-1:0] chan_addr;
   logic [NCH-1:0]        match;
   logic [NCH-1:0]        set_req;

   rom_patch_regs #(.ADDR_W(ADDR_W), .NCH(NCH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .set_req   (set_req),
      .rdata     (reg_rdata),
      .chan_en   (chan_en),
      .chan_addr (chan_addr)
   );

   rom_patch_cmp #(.ADDR_W(ADDR_W), .NCH(NCH)) u_cmp (
      .fetch_addr (fetch_addr),
      .chan_en    (chan_en),
      .chan_addr  (chan_addr),
      .match      (match)
   );

   rom_patch_inject #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NCH       (NCH),
      .BRANCH_OP (DATA_W'(BRANCH_OP)),
      .VECTOR    (ADDR_W'(VECTOR))
   ) u_inject (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_valid  (fetch_valid),
      .fetch_opcode (fetch_opcode),
      .rom_data     (rom_data),
      .match        (match),
      .fetch_data   (fetch_data),
      .set_req      (set_req)
   );

endmodule

// File: tb/rom_patch_unit_test.sv
module rom_patch_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic        fetch_opcode = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic [7:0]  rom_data = '0;
   logic [7:0]  fetch_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   logic [3:0]  m_ctrl = '0;
   logic [15:0] m_a0 = '0;
   logic [15:0] m_a1 = '0;
   int          m_seq = 0;

   always #5 clk = ~clk;

   rom_patch_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
      .fetch_opcode(fetch_opcode), .fetch_addr(fetch_addr), .rom_data(rom_data),
      .fetch_data(fetch_data)
   );

   function automatic logic m_match0();
      return m_ctrl[1] && (m_a0 == fetch_addr);
   endfunction
   function automatic logic m_match1();
      return m_ctrl[3] && (m_a1 == fetch_addr);
   endfunction
   function automatic logic m_hit();
      return fetch_valid && fetch_opcode && (m_seq == 0) && (m_match0() || m_match1());
   endfunction
   function automatic logic [7:0] exp_data();
      if (fetch_valid && m_seq == 1) return 8'hFD;
      if (fetch_valid && m_seq == 2) return 8'hF7;
      if (m_hit()) return 8'h9B;
      return rom_data;
   endfunction
   function automatic logic [15:0] exp_rdata();
      case (reg_sel)
         2'd0:    return {12'h000, m_ctrl};
         2'd1:    return m_a0;
         2'd2:    return m_a1;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: drive, compare at mid-cycle, then advance the model at the edge
   task automatic step(input logic fv, input logic fo, input logic [15:0] fa,
                       input logic [7:0] rd, input logic wr, input logic [1:0] sel,
                       input logic [15:0] wd, input string tag);
      string dtag, rtag;
      logic  h, h0, h1;
      @(negedge clk);
      fetch_valid = fv; fetch_opcode = fo; fetch_addr = fa; rom_data = rd;
      reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      #1;
      if (m_seq != 0 && fv)        dtag = "R5";
      else if (m_hit())            dtag = "R4";
      else if (fv && !fo)          dtag = "R8";
      else                         dtag = "R3";
      rtag = (sel == 2'd0) ? "R6" : "R2";
      if (tag != "") begin dtag = tag; rtag = tag; end
      check(dtag, {8'h00, fetch_data}, {8'h00, exp_data()});
      check(rtag, reg_rdata, exp_rdata());
      h = m_hit(); h0 = m_match0(); h1 = m_match1();
      @(posedge clk);
      if (wr && sel == 2'd0) m_ctrl = wd[3:0];
      if (wr && sel == 2'd1) m_a0 = wd;
      if (wr && sel == 2'd2) m_a1 = wd;
      if (h && h0) m_ctrl[0] = 1'b1;
      if (h && h1) m_ctrl[2] = 1'b1;
      if (h) m_seq = 1;
      else if (m_seq != 0 && fv) m_seq = (m_seq == 2) ? 0 : m_seq + 1;
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [15:0] wd);
      step(1'b0, 1'b0, 16'h0, 8'h00, 1'b1, sel, wd, "R2");
   endtask
   task automatic rreg(input logic [1:0] sel, input string tag);
      step(1'b0, 1'b0, 16'h0, 8'h00, 1'b0, sel, 16'h0, tag);
   endtask
   task automatic fetch(input logic fo, input logic [15:0] fa, input logic [7:0] rd, input string tag);
      step(1'b1, fo, fa, rd, 1'b0, 2'd3, 16'h0, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset state
      step(1'b1, 1'b1, 16'h0000, 8'h5A, 1'b0, 2'd0, 16'h0, "R1");
      rreg(2'd1, "R1");
      rreg(2'd2, "R1");
      rreg(2'd3, "R2");

      // R2 program addresses, enable channel 0 only
      wreg(2'd1, 16'h1234);
      wreg(2'd2, 16'h2000);
      rreg(2'd1, "R2");
      rreg(2'd2, "R2");
      wreg(2'd0, 16'hFFF2);
      rreg(2'd0, "R2");

      // R3 disabled channel 1 does not fire
      fetch(1'b1, 16'h2000, 8'h11, "R3");
      rreg(2'd0, "R3");
      // R8 operand read of armed address passes
      fetch(1'b0, 16'h1234, 8'h22, "R8");
      // R4 hit, R11 idle gap, R5 trailing bytes, R10 match during injection
      wreg(2'd0, 16'h000A);
      fetch(1'b1, 16'h1234, 8'h33, "R4");
      rreg(2'd0, "R6");
      fetch(1'b1, 16'h2000, 8'h44, "R10");
      step(1'b0, 1'b0, 16'h0, 8'h55, 1'b0, 2'd3, 16'h0, "R11");
      fetch(1'b1, 16'h1234, 8'h66, "R10");
      rreg(2'd0, "R10");
      // R6 sticky across later traffic
      fetch(1'b1, 16'h0100, 8'h77, "R6");
      rreg(2'd0, "R6");
      // R7 write of zero clears and disables
      wreg(2'd0, 16'h0000);
      rreg(2'd0, "R7");
      fetch(1'b1, 16'h1234, 8'h88, "R7");
      // R7 write in same cycle as hit keeps the set
      wreg(2'd0, 16'h0002);
      step(1'b1, 1'b1, 16'h1234, 8'h99, 1'b1, 2'd0, 16'h0002, "R7");
      fetch(1'b1, 16'h1235, 8'h01, "R5");
      fetch(1'b1, 16'h1236, 8'h02, "R5");
      rreg(2'd0, "R7");
      // R9 equal addresses on both channels
      wreg(2'd2, 16'h1234);
      wreg(2'd0, 16'h000A);
      fetch(1'b1, 16'h1234, 8'hAB, "R9");
      rreg(2'd0, "R9");
      fetch(1'b1, 16'h1235, 8'hAC, "R9");
      fetch(1'b1, 16'h1236, 8'hAD, "R9");
      rreg(2'd0, "R9");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] fa;
         logic [15:0] wd;
         logic        wr;
         logic [1:0]  sel;
         case ($urandom_range(0, 3))
            0:       fa = m_a0;
            1:       fa = m_a1;
            default: fa = 16'(16'h1230 + $urandom_range(0, 7));
         endcase
         wr  = ($urandom_range(0, 15) == 0);
         sel = 2'($urandom_range(0, 3));
         if (sel == 2'd0) wd = 16'($urandom_range(0, 15));
         else             wd = 16'(16'h1230 + $urandom_range(0, 7));
         step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), fa,
              8'($urandom_range(0, 255)), wr, sel, wd, "");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule